// File: doc/BRIEF.md
# Linked-List DMA Transfer Engine

This block is the data mover of a multi-channel DMA controller. Each channel holds a source address, a destination address, a link pointer, a control word and a configuration word. The engine scans the channels and picks one that is enabled, not halted, has a nonzero element count and whose flow-control mode is satisfied by the peripheral request lines. For that channel it moves one element: it reads the element through a memory master port, then writes it back. After each element it advances the addresses and lowers the count.

When a channel's count runs out, the engine does one of two things. If the link pointer is nonzero, it fetches a four-word descriptor from memory and carries on with it. If the pointer is zero, it turns the channel off. The control word can ask for a terminal-count flag when the channel completes.

Channel registers are loaded through a single-cycle write port. Memory accesses use a request/done handshake: the request is held until the memory pulses done for one cycle. Read data and write data are right-justified, so an element sits in the low bytes of the 32-bit word.

Top module: `dma_chan_engine`

## Requirements
- R1: No element moves while `glob_en` is 0. While it is 0, the scan position is held at channel 0, so scanning starts from channel 0 once it is raised.
- R2: A channel can move data only when configuration bit 0 (enable) is 1 and configuration bit 18 (halt) is 0. A halted channel keeps its enable bit.
- R3: Configuration bits 13:11 select the flow mode. Bits 5:1 give the source peripheral number and bits 10:6 the destination peripheral number. A peripheral counts as requesting when its bit is set in `req_single` OR `req_burst`. Mode 0 needs no request. Mode 1 needs the destination request. Mode 2 needs the source request. Mode 3 needs both. Modes 4 to 7 never move data.
- R4: Control bits 11:0 hold the remaining element count. A channel whose count is zero is skipped. The count drops by one after each element, so a channel moves exactly as many elements as its starting count.
- R5: The source width code is control bits 20:18 and the destination width code is bits 23:21. A channel moves data only when both codes are equal and at most 2, giving 1, 2 or 4 bytes. That code is driven on `mem_size` for element accesses, and descriptor reads use code 2.
- R6: Control bit 26 makes the source address advance by the element width after each element. Control bit 27 does the same for the destination address. When a bit is clear, that address stays fixed.
- R7: When the count reaches zero and the link register is nonzero, the engine reads four words in this order: link+0 into source, link+4 into destination, link+12 into control, and link+8 into link. Service then continues with the new descriptor.
- R8: When the count reaches zero and the link register is zero, the engine clears the channel's enable bit.
- R9: When control bit 31 of the finishing descriptor is set, the channel's bit in `tc_raw` is set at completion. A 1 on `tc_clr` clears that bit, and the flag stays 0 for channels whose bit 31 was clear.
- R10: Channels are examined from index 0 upward. After an element, the same channel is examined again, so a lower channel that stays eligible finishes all its elements before a higher channel moves any.
- R11: While `mem_req` is 1 and `mem_done` has not been seen, `mem_req`, `mem_we` and `mem_addr` stay unchanged.
- R12: After reset, `busy`, `mem_req`, `chan_en` and `tc_raw` are all 0.
- R13: A write with `cfg_we` loads the register picked by `cfg_fld` for channel `cfg_chan` at the next edge. The codes are 0 source, 1 destination, 2 link, 3 control and 4 configuration. In the same cycle, the write takes priority over an engine update of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en | input | 1 | Global engine enable |
| cfg_we | input | 1 | Channel register write strobe |
| cfg_chan | input | $clog2(NCHAN) | Channel selected for the write |
| cfg_fld | input | 3 | Register selected for the write |
| cfg_wdata | input | 32 | Write data |
| req_single | input | NPER | Single request lines from peripherals |
| req_burst | input | NPER | Burst request lines from peripherals |
| tc_clr | input | NCHAN | Clears terminal-count flags |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Byte address |
| mem_size | output | 2 | Access width code (bytes = 2^code) |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, right-justified |
| mem_done | input | 1 | One-cycle completion pulse |
| busy | output | 1 | An element or descriptor access is in flight |
| chan_en | output | NCHAN | Enable bit of each channel |
| tc_raw | output | NCHAN | Raw terminal-count flags |

## Verification
A register write shows on `chan_en` one edge after the strobe. A newly eligible channel issues its read request one edge after that. Each element then needs a read and a write, and each access completes one edge after its done pulse. Flag and enable changes show at the edge that accepts the write's done pulse, and a descriptor reload adds four more accesses. With the bench memory answering two cycles after a request, an element takes about six cycles. The bench therefore drives inputs on falling edges and waits fixed windows of 40 to 100 cycles, well beyond the worst case, before it samples the ports and the memory log on a falling edge. Request stability is tracked on every falling edge.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

   localparam int REG_W       = 32;
   localparam int CONF_EN     = 0;
   localparam int CONF_HALT   = 18;
   localparam int CONF_SPER   = 1;
   localparam int CONF_DPER   = 6;
   localparam int CONF_FLOW   = 11;
   localparam int CTRL_SWID   = 18;
   localparam int CTRL_DWID   = 21;
   localparam int CTRL_SINC   = 26;
   localparam int CTRL_DINC   = 27;
   localparam int CTRL_TCIRQ  = 31;

   typedef enum logic [1:0] {
      ST_SCAN  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_LINK  = 2'd3
   } eng_state_e;

   typedef enum logic [2:0] {
      FLD_SRC  = 3'd0,
      FLD_DST  = 3'd1,
      FLD_LINK = 3'd2,
      FLD_CTRL = 3'd3,
      FLD_CONF = 3'd4
   } fld_e;

   // byte offset of descriptor word fetched in step idx
   function automatic logic [3:0] link_offset(input logic [1:0] idx);
      case (idx)
         2'd0:    return 4'd0;
         2'd1:    return 4'd4;
         2'd2:    return 4'd12;
         default: return 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_eng_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_fld,
   input  logic [REG_W-1:0]  cfg_wdata,
   input  logic              upd_src_we,
   input  logic [ADDR_W-1:0] upd_src,
   input  logic              upd_dst_we,
   input  logic [ADDR_W-1:0] upd_dst,
   input  logic              upd_link_we,
   input  logic [ADDR_W-1:0] upd_link,
   input  logic              upd_ctrl_we,
   input  logic [REG_W-1:0]  upd_ctrl,
   input  logic              upd_dis,
   output logic [ADDR_W-1:0] src_q,
   output logic [ADDR_W-1:0] dst_q,
   output logic [ADDR_W-1:0] link_q,
   output logic [REG_W-1:0]  ctrl_q,
   output logic [REG_W-1:0]  conf_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         link_q <= '0;
         ctrl_q <= '0;
         conf_q <= '0;
      end else begin
         if (upd_src_we)  src_q  <= upd_src;
         if (upd_dst_we)  dst_q  <= upd_dst;
         if (upd_link_we) link_q <= upd_link;
         if (upd_ctrl_we) ctrl_q <= upd_ctrl;
         if (upd_dis)     conf_q[CONF_EN] <= 1'b0;
         // register writes come last and so win over engine updates
         if (cfg_we) begin
            case (fld_e'(cfg_fld))
               FLD_SRC:  src_q  <= cfg_wdata[ADDR_W-1:0];
               FLD_DST:  dst_q  <= cfg_wdata[ADDR_W-1:0];
               FLD_LINK: link_q <= cfg_wdata[ADDR_W-1:0];
               FLD_CTRL: ctrl_q <= cfg_wdata;
               FLD_CONF: conf_q <= cfg_wdata;
               default:  ;
            endcase
         end
      end
   end

endmodule

// File: rtl/dma_flow_gate.sv
module dma_flow_gate
   import dma_eng_pkg::*;
#(
   parameter int NPER  = 32,
   parameter int CNT_W = 12
) (
   input  logic [REG_W-1:0] conf,
   input  logic [REG_W-1:0] ctrl,
   input  logic [NPER-1:0]  req_any,
   output logic             elig
);

   logic [31:0] req_ext;
   logic [4:0]  sper, dper;
   logic [2:0]  flow, swid, dwid;
   logic        sreq, dreq, flow_ok, width_ok, armed, cnt_nz;
   logic        unused_bits;

   assign req_ext  = 32'(req_any);
   assign sper     = conf[CONF_SPER +: 5];
   assign dper     = conf[CONF_DPER +: 5];
   assign flow     = conf[CONF_FLOW +: 3];
   assign swid     = ctrl[CTRL_SWID +: 3];
   assign dwid     = ctrl[CTRL_DWID +: 3];
   assign sreq     = req_ext[sper];
   assign dreq     = req_ext[dper];
   assign armed    = conf[CONF_EN] & ~conf[CONF_HALT];
   assign cnt_nz   = |ctrl[CNT_W-1:0];
   assign width_ok = (swid == dwid) && (swid <= 3'd2);

   always_comb begin
      case (flow)
         3'd0:    flow_ok = 1'b1;
         3'd1:    flow_ok = dreq;
         3'd2:    flow_ok = sreq;
         3'd3:    flow_ok = sreq & dreq;
         default: flow_ok = 1'b0;
      endcase
   end

   assign elig = armed & cnt_nz & width_ok & flow_ok;

   assign unused_bits = ^{conf[REG_W-1:CONF_HALT+1], conf[CONF_HALT-1:CONF_FLOW+3],
                          ctrl[REG_W-1:CTRL_DWID+3], ctrl[CTRL_SWID-1:CNT_W]};

endmodule

// File: rtl/dma_eng_seq.sv
module dma_eng_seq
   import dma_eng_pkg::*;
#(
   parameter int NCHAN  = 4,
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 12,
   localparam int CH_W  = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         glob_en,
   input  logic [NCHAN-1:0]             elig,
   input  logic [NCHAN-1:0][ADDR_W-1:0] src_all,
   input  logic [NCHAN-1:0][ADDR_W-1:0] dst_all,
   input  logic [NCHAN-1:0][ADDR_W-1:0] link_all,
   input  logic [NCHAN-1:0][REG_W-1:0]  ctrl_all,
   input  logic                         mem_done,
   input  logic [REG_W-1:0]             mem_rdata,
   output logic                         mem_req,
   output logic                         mem_we,
   output logic [ADDR_W-1:0]            mem_addr,
   output logic [1:0]                   mem_size,
   output logic [REG_W-1:0]             mem_wdata,
   output logic [CH_W-1:0]              cur,
   output logic                         upd_src_we,
   output logic [ADDR_W-1:0]            upd_src,
   output logic                         upd_dst_we,
   output logic [ADDR_W-1:0]            upd_dst,
   output logic                         upd_link_we,
   output logic [ADDR_W-1:0]            upd_link,
   output logic                         upd_ctrl_we,
   output logic [REG_W-1:0]             upd_ctrl,
   output logic                         upd_dis,
   output logic [NCHAN-1:0]             tc_set,
   output logic                         busy
);

   eng_state_e        state;
   logic [1:0]        lidx;
   logic [REG_W-1:0]  data_q;
   logic [ADDR_W-1:0] cur_src, cur_dst, cur_link, step;
   logic [REG_W-1:0]  cur_ctrl;
   logic [1:0]        wcode;
   logic [CNT_W-1:0]  cnt_nx;
   logic              last_elem, chain;

   assign cur_src   = src_all[cur];
   assign cur_dst   = dst_all[cur];
   assign cur_link  = link_all[cur];
   assign cur_ctrl  = ctrl_all[cur];
   assign wcode     = cur_ctrl[CTRL_SWID +: 2];
   assign step      = ADDR_W'(1) << wcode;
   assign cnt_nx    = cur_ctrl[CNT_W-1:0] - 1'b1;
   assign last_elem = (cnt_nx == '0);
   assign chain     = last_elem && (cur_link != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_SCAN;
         cur    <= '0;
         lidx   <= '0;
         data_q <= '0;
      end else begin
         case (state)
            ST_SCAN: begin
               if (!glob_en)       cur <= '0;
               else if (elig[cur]) state <= ST_READ;
               else                cur <= (cur == CH_W'(NCHAN - 1)) ? '0 : cur + 1'b1;
            end
            ST_READ: if (mem_done) begin
               data_q <= mem_rdata;
               state  <= ST_WRITE;
            end
            ST_WRITE: if (mem_done) begin
               lidx  <= '0;
               state <= chain ? ST_LINK : ST_SCAN;
            end
            default: if (mem_done) begin
               lidx <= lidx + 1'b1;
               if (lidx == 2'd3) state <= ST_SCAN;
            end
         endcase
      end
   end

   always_comb begin
      mem_req   = (state != ST_SCAN);
      mem_we    = (state == ST_WRITE);
      mem_wdata = data_q;
      mem_size  = (state == ST_LINK) ? 2'd2 : wcode;
      case (state)
         ST_WRITE: mem_addr = cur_dst;
         ST_LINK:  mem_addr = cur_link + ADDR_W'(link_offset(lidx));
         default:  mem_addr = cur_src;
      endcase

      upd_src_we  = 1'b0;
      upd_dst_we  = 1'b0;
      upd_link_we = 1'b0;
      upd_ctrl_we = 1'b0;
      upd_dis     = 1'b0;
      tc_set      = '0;
      upd_src     = cur_src + step;
      upd_dst     = cur_dst + step;
      upd_link    = mem_rdata[ADDR_W-1:0];
      upd_ctrl    = {cur_ctrl[REG_W-1:CNT_W], cnt_nx};

      if (mem_done && state == ST_WRITE) begin
         upd_src_we  = cur_ctrl[CTRL_SINC];
         upd_dst_we  = cur_ctrl[CTRL_DINC];
         upd_ctrl_we = 1'b1;
         upd_dis     = last_elem && (cur_link == '0);
         tc_set[cur] = last_elem && cur_ctrl[CTRL_TCIRQ];
      end else if (mem_done && state == ST_LINK) begin
         upd_src     = mem_rdata[ADDR_W-1:0];
         upd_dst     = mem_rdata[ADDR_W-1:0];
         upd_ctrl    = mem_rdata;
         upd_src_we  = (lidx == 2'd0);
         upd_dst_we  = (lidx == 2'd1);
         upd_ctrl_we = (lidx == 2'd2);
         upd_link_we = (lidx == 2'd3);
      end
   end

   assign busy = (state != ST_SCAN);

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
   import dma_eng_pkg::*;
#(
   parameter int NCHAN  = 4,
   parameter int NPER   = 32,
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 12
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              glob_en,
   input  logic                              cfg_we,
   input  logic [$clog2(NCHAN > 1 ? NCHAN : 2)-1:0] cfg_chan,
   input  logic [2:0]                        cfg_fld,
   input  logic [31:0]                       cfg_wdata,
   input  logic [NPER-1:0]                   req_single,
   input  logic [NPER-1:0]                   req_burst,
   input  logic [NCHAN-1:0]                  tc_clr,
   output logic                              mem_req,
   output logic                              mem_we,
   output logic [ADDR_W-1:0]                 mem_addr,
   output logic [1:0]                        mem_size,
   output logic [31:0]                       mem_wdata,
   input  logic [31:0]                       mem_rdata,
   input  logic                              mem_done,
   output logic                              busy,
   output logic [NCHAN-1:0]                  chan_en,
   output logic [NCHAN-1:0]                  tc_raw
);

   localparam int CH_W = (NCHAN > 1) ? $clog2(NCHAN) : 1;

   if (NCHAN < 1 || NCHAN > 32) begin : g_bad_nchan
      $error("NCHAN must be 1..32");
   end
   if (NPER < 1 || NPER > 32) begin : g_bad_nper
      $error("NPER must be 1..32");
   end
   if (ADDR_W < 8 || ADDR_W > REG_W) begin : g_bad_addr
      $error("ADDR_W must be 8..32");
   end
   if (CNT_W < 1 || CNT_W > CTRL_SWID) begin : g_bad_cnt
      $error("CNT_W must fit below the width fields");
   end

   logic [NCHAN-1:0][ADDR_W-1:0] src_all, dst_all, link_all;
   logic [NCHAN-1:0][REG_W-1:0]  ctrl_all, conf_all;
   logic [NCHAN-1:0]             elig, tc_set;
   logic [NPER-1:0]              req_any;
   logic [CH_W-1:0]              cur;
   logic                         s_we, d_we, l_we, c_we, dis;
   logic [ADDR_W-1:0]            s_val, d_val, l_val;
   logic [REG_W-1:0]             c_val;

   assign req_any = req_single | req_burst;

   for (genvar i = 0; i < NCHAN; i++) begin : g_chan
      logic sel;
      assign sel = (cur == CH_W'(i));

      dma_chan_regs #(.ADDR_W(ADDR_W)) u_regs (
         .clk, .rst_n,
         .cfg_we      (cfg_we && (cfg_chan == CH_W'(i))),
         .cfg_fld,
         .cfg_wdata,
         .upd_src_we  (s_we & sel),
         .upd_src     (s_val),
         .upd_dst_we  (d_we & sel),
         .upd_dst     (d_val),
         .upd_link_we (l_we & sel),
         .upd_link    (l_val),
         .upd_ctrl_we (c_we & sel),
         .upd_ctrl    (c_val),
         .upd_dis     (dis & sel),
         .src_q       (src_all[i]),
         .dst_q       (dst_all[i]),
         .link_q      (link_all[i]),
         .ctrl_q      (ctrl_all[i]),
         .conf_q      (conf_all[i])
      );

      dma_flow_gate #(.NPER(NPER), .CNT_W(CNT_W)) u_gate (
         .conf    (conf_all[i]),
         .ctrl    (ctrl_all[i]),
         .req_any (req_any),
         .elig    (elig[i])
      );

      assign chan_en[i] = conf_all[i][CONF_EN];
   end

   dma_eng_seq #(.NCHAN(NCHAN), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
      .clk, .rst_n, .glob_en, .elig,
      .src_all, .dst_all, .link_all, .ctrl_all,
      .mem_done, .mem_rdata, .mem_req, .mem_we, .mem_addr, .mem_size, .mem_wdata,
      .cur,
      .upd_src_we (s_we), .upd_src (s_val),
      .upd_dst_we (d_we), .upd_dst (d_val),
      .upd_link_we(l_we), .upd_link(l_val),
      .upd_ctrl_we(c_we), .upd_ctrl(c_val),
      .upd_dis    (dis),
      .tc_set, .busy
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tc_raw <= '0;
      else        tc_raw <= (tc_raw & ~tc_clr) | tc_set;
   end

endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
   parameter int NCHAN  = 4,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              glob_en,
   input logic              cfg_we,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [1:0]        mem_size,
   input logic              mem_done,
   input logic              busy,
   input logic [NCHAN-1:0]  chan_en,
   input logic [NCHAN-1:0]  tc_raw
);

   // R11: request fields hold until done
   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R1: an idle engine stays idle while globally disabled
   a_r1_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_en && !busy) |=> !busy);

   // R5: only 1, 2 or 4 byte accesses
   a_r5_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_size <= 2'd2));

   for (genvar i = 0; i < NCHAN; i++) begin : g_ch
      // R8: enable drops on its own only after a completed write
      a_r8_en_clear: assert property (@(posedge clk) disable iff (!rst_n)
         ($fell(chan_en[i]) && !$past(cfg_we)) |-> $past(mem_done && mem_we));
      // R9: terminal flag rises only after a completed write
      a_r9_tc_source: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(tc_raw[i]) |-> $past(mem_done && mem_we));
   end

endmodule

bind dma_chan_engine dma_chan_engine_chk #(.NCHAN(NCHAN), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .cfg_we(cfg_we),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
   .mem_done(mem_done), .busy(busy), .chan_en(chan_en), .tc_raw(tc_raw)
);

// File: tb/dma_chan_engine_bench.sv
module dma_chan_engine_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;

   // {flow[2:0], src3_single, dst7_single, src3_burst, dst7_burst, expect}
   localparam logic [7:0] VEC [10] = '{
      8'b000_0000_1, 8'b001_0000_0, 8'b001_0100_1, 8'b001_0010_0, 8'b010_0010_1,
      8'b010_0100_0, 8'b011_1001_1, 8'b011_1000_0, 8'b100_1111_0, 8'b111_0000_0
   };

   logic        clk = 1'b0, rst_n = 1'b0, glob_en = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_chan = '0;
   logic [2:0]  cfg_fld = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] req_single = '0, req_burst = '0;
   logic [NCH-1:0] tc_clr = '0;
   logic        mem_req, mem_we, mem_done, busy;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [1:0]  mem_size;
   logic [NCH-1:0] chan_en, tc_raw;

   dma_chan_engine #(.NCHAN(NCH)) u_dma_chan_engine (
      .clk, .rst_n, .glob_en, .cfg_we, .cfg_chan, .cfg_fld, .cfg_wdata,
      .req_single, .req_burst, .tc_clr,
      .mem_req, .mem_we, .mem_addr, .mem_size, .mem_wdata, .mem_rdata, .mem_done,
      .busy, .chan_en, .tc_raw
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // memory model: done two cycles after request, access log
   logic [7:0]  mem [256];
   logic [7:0]  log_addr [64];
   logic        log_we [64];
   logic [1:0]  log_size [64];
   int          n_log = 0, n_wr = 0;
   logic        wcnt = 1'b0;
   logic        poke_we = 1'b0, log_clr = 1'b0;
   logic [7:0]  poke_addr = '0, poke_data = '0;
   logic [7:0]  ra;

   assign ra = mem_addr[7:0];
   assign mem_rdata = {mem[8'(ra+3)], mem[8'(ra+2)], mem[8'(ra+1)], mem[ra]};

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_done <= 1'b0;
         wcnt     <= 1'b0;
      end else begin
         mem_done <= 1'b0;
         if (mem_req && !mem_done) begin
            if (wcnt) begin mem_done <= 1'b1; wcnt <= 1'b0; end
            else wcnt <= 1'b1;
         end
         if (mem_req && mem_done) begin
            if (n_log < 64) begin
               log_addr[n_log] <= ra;
               log_we[n_log]   <= mem_we;
               log_size[n_log] <= mem_size;
            end
            n_log <= n_log + 1;
            if (mem_we) begin
               n_wr <= n_wr + 1;
               for (int k = 0; k < 4; k++)
                  if (k < (1 << mem_size)) mem[8'(ra + k)] <= mem_wdata[8*k +: 8];
            end
         end
      end
      if (poke_we) mem[poke_addr] <= poke_data;
      if (log_clr) begin n_log <= 0; n_wr <= 0; end
   end

   // R11 monitor on falling edges
   int   hold_err = 0;
   logic last_req = 1'b0, last_done = 1'b0;
   logic [31:0] last_addr = '0;
   always @(negedge clk) begin
      if (rst_n && mem_req && last_req && !last_done && mem_addr != last_addr) hold_err++;
      last_req  = mem_req;
      last_done = mem_done;
      last_addr = mem_addr;
   end

   int errors = 0, checks = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(input int ch, input int fld, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_fld = 3'(fld); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic poke(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      poke_we = 1'b1; poke_addr = a; poke_data = d;
      @(negedge clk);
      poke_we = 1'b0;
   endtask

   task automatic poke_word(input logic [7:0] a, input logic [31:0] w);
      for (int k = 0; k < 4; k++) poke(8'(a + k), w[8*k +: 8]);
   endtask

   task automatic clear_log();
      @(negedge clk); log_clr = 1'b1;
      @(negedge clk); log_clr = 1'b0;
   endtask

   function automatic logic [31:0] ctrl_w(input int cnt, input int w, input bit si,
                                          input bit di, input bit tc);
      return (32'(tc) << 31) | (32'(di) << 27) | (32'(si) << 26) |
             (32'(w) << 21) | (32'(w) << 18) | 32'(cnt);
   endfunction

   function automatic logic [31:0] conf_w(input bit en, input bit halt, input int flow,
                                          input int sp, input int dp);
      return 32'(en) | (32'(sp) << 1) | (32'(dp) << 6) | (32'(flow) << 11) | (32'(halt) << 18);
   endfunction

   task automatic chan(input int ch, input logic [31:0] s, input logic [31:0] d,
                       input logic [31:0] l, input logic [31:0] c, input logic [31:0] f);
      cfg(ch, 0, s); cfg(ch, 1, d); cfg(ch, 2, l); cfg(ch, 3, c); cfg(ch, 4, f);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      cyc(3);
      // R12: reset state
      chk(busy == 0 && mem_req == 0, "R12 busy/req in reset", {busy, mem_req}, 0);
      chk(chan_en == 0 && tc_raw == 0, "R12 enables/flags in reset", {chan_en, tc_raw}, 0);
      rst_n = 1'b1;
      cyc(2);
      chk(busy == 0 && chan_en == 0 && tc_raw == 0, "R12 after release",
          {busy, chan_en, tc_raw}, 0);

      // R1, R13, R4, R8, R6: global gate, then two byte elements
      poke(8'h10, 8'hA5); poke(8'h11, 8'h5A);
      clear_log();
      chan(0, 32'h10, 32'h30, 0, ctrl_w(2, 0, 1, 1, 0), conf_w(1, 0, 0, 0, 0));
      cyc(40);
      chk(n_wr == 0, "R1 no move while glob_en=0", n_wr, 0);
      chk(chan_en[0] == 1'b1, "R13 configuration write loaded", chan_en[0], 1);
      glob_en = 1'b1;
      cyc(60);
      chk(n_wr == 2, "R4 element count", n_wr, 2);
      chk(chan_en[0] == 1'b0, "R8 enable cleared at end", chan_en[0], 0);
      chk({mem[8'h31], mem[8'h30]} == 16'h5AA5, "R6 incremented copy",
          {mem[8'h31], mem[8'h30]}, 16'h5AA5);

      // R3: flow-mode table
      for (int i = 0; i < 10; i++) begin
         logic [7:0] v;
         v = VEC[i];
         clear_log();
         req_single = (32'(v[4]) << 3) | (32'(v[3]) << 7);
         req_burst  = (32'(v[2]) << 3) | (32'(v[1]) << 7);
         chan(0, 32'h10, 32'h40, 0, ctrl_w(1, 0, 0, 0, 0), conf_w(1, 0, int'(v[7:5]), 3, 7));
         cyc(40);
         chk(n_wr == int'(v[0]), $sformatf("R3 flow vector %0d", i), n_wr, v[0]);
         cfg(0, 4, 0);
         req_single = '0; req_burst = '0;
      end
      chk(tc_raw == 0, "R9 no flag without control bit 31", tc_raw, 0);

      // R2: halt
      clear_log();
      chan(0, 32'h10, 32'h40, 0, ctrl_w(1, 0, 0, 0, 0), conf_w(1, 1, 0, 0, 0));
      cyc(40);
      chk(n_wr == 0, "R2 halted channel idle", n_wr, 0);
      chk(chan_en[0] == 1'b1, "R2 halted channel keeps enable", chan_en[0], 1);
      cfg(0, 4, conf_w(1, 0, 0, 0, 0));
      cyc(40);
      chk(n_wr == 1, "R2 moves after halt cleared", n_wr, 1);

      // R4: zero count skipped
      clear_log();
      chan(0, 32'h10, 32'h40, 0, ctrl_w(0, 0, 0, 0, 0), conf_w(1, 0, 0, 0, 0));
      cyc(40);
      chk(n_wr == 0 && chan_en[0] == 1'b1, "R4 zero count skipped", {n_wr, chan_en[0]}, 1);
      cfg(0, 4, 0);

      // R5: unequal widths and width code 3
      clear_log();
      chan(0, 32'h10, 32'h40, 0, 32'h0000_0001 | (32'd2 << 21), conf_w(1, 0, 0, 0, 0));
      cyc(40);
      chk(n_wr == 0, "R5 unequal widths not moved", n_wr, 0);
      cfg(0, 4, 0);
      chan(0, 32'h10, 32'h40, 0, ctrl_w(1, 3, 0, 0, 0), conf_w(1, 0, 0, 0, 0));
      cyc(40);
      chk(n_wr == 0, "R5 width code 3 not moved", n_wr, 0);
      cfg(0, 4, 0);

      // R5, R6: halfword elements
      poke_word(8'h18, 32'h44332211);
      clear_log();
      chan(0, 32'h18, 32'h50, 0, ctrl_w(2, 1, 1, 1, 0), conf_w(1, 0, 0, 0, 0));
      cyc(60);
      chk(n_wr == 2 && log_size[1] == 2'd1, "R5 halfword size code", log_size[1], 1);
      chk({mem[8'h53], mem[8'h52], mem[8'h51], mem[8'h50]} == 32'h44332211,
          "R6 halfword copy", {mem[8'h53], mem[8'h52], mem[8'h51], mem[8'h50]}, 32'h44332211);

      // R6: fixed destination, word elements
      poke_word(8'h60, 32'h04030201); poke_word(8'h64, 32'h08070605);
      poke_word(8'h68, 32'h0C0B0A09);
      clear_log();
      chan(0, 32'h60, 32'h70, 0, ctrl_w(3, 2, 1, 0, 0), conf_w(1, 0, 0, 0, 0));
      cyc(80);
      chk(log_addr[4] == 8'h68 && log_addr[5] == 8'h70, "R6 source steps, destination fixed",
          {log_addr[4], log_addr[5]}, 16'h6870);
      chk({mem[8'h73], mem[8'h72], mem[8'h71], mem[8'h70]} == 32'h0C0B0A09,
          "R6 last word kept", {mem[8'h73], mem[8'h72], mem[8'h71], mem[8'h70]}, 32'h0C0B0A09);

      // R7, R8, R9: linked descriptor
      poke_word(8'h80, 32'h10); poke_word(8'h84, 32'h90);
      poke_word(8'h88, 32'h0);  poke_word(8'h8C, ctrl_w(1, 0, 0, 0, 1));
      clear_log();
      chan(0, 32'h11, 32'h98, 32'h80, ctrl_w(1, 0, 0, 0, 0), conf_w(1, 0, 0, 0, 0));
      cyc(100);
      chk(n_log == 8, "R7 access count", n_log, 8);
      chk({log_addr[2], log_addr[3], log_addr[4], log_addr[5]} == 32'h80848C88,
          "R7 descriptor fetch order",
          {log_addr[2], log_addr[3], log_addr[4], log_addr[5]}, 32'h80848C88);
      chk(log_addr[6] == 8'h10 && log_addr[7] == 8'h90 && log_we[7],
          "R7 new descriptor serviced", {log_addr[6], log_addr[7]}, 16'h1090);
      chk(mem[8'h98] == 8'h5A && mem[8'h90] == 8'hA5, "R7 data of both descriptors",
          {mem[8'h98], mem[8'h90]}, 16'h5AA5);
      chk(chan_en[0] == 1'b0, "R8 end of chain disables", chan_en[0], 0);
      chk(tc_raw == 4'b0001, "R9 flag set at completion", tc_raw, 1);
      @(negedge clk); tc_clr = 4'b0001;
      @(negedge clk); tc_clr = '0;
      chk(tc_raw == 0, "R9 flag cleared", tc_raw, 0);

      // R10, R1: channel order
      glob_en = 1'b0;
      chan(1, 32'h18, 32'hB0, 0, ctrl_w(2, 0, 1, 1, 0), conf_w(1, 0, 0, 0, 0));
      chan(0, 32'h10, 32'hA0, 0, ctrl_w(2, 0, 1, 1, 0), conf_w(1, 0, 0, 0, 0));
      clear_log();
      glob_en = 1'b1;
      cyc(80);
      chk({log_addr[1], log_addr[3], log_addr[5], log_addr[7]} == 32'hA0A1B0B1,
          "R10 lower channel drains first",
          {log_addr[1], log_addr[3], log_addr[5], log_addr[7]}, 32'hA0A1B0B1);

      chk(hold_err == 0, "R11 request held until done", hold_err, 0);
      summary();
   end

endmodule